// File: doc/BRIEF.md
# Fixed-Point Accumulator Execute Unit

This block is the arithmetic core of a small audio signal processor that works on 24-bit signed fractions. It keeps an accumulator and a second register that always holds the accumulator value from before the most recent executed instruction. It also owns a 64-entry general register file. Each valid 32-bit instruction word names one operation. The unit executes it in a single clock and updates the accumulator, the previous-value register and, for the store forms, one register file entry. Delay memory, oscillators and the logarithm and exponent operations are handled elsewhere. The accumulator and its previous value are brought out so that a neighbouring branch unit can evaluate its conditions.

All arithmetic operations share one multiply-add path. A selected base term, scaled to the product's binary point, is added to the full-width product of a signed coefficient and a selected difference term. The sum is then shifted back and clamped to the 24-bit range. Register multiply, max-of-magnitudes and the three bitwise operations have their own short paths.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset the accumulator, the previous-value register and all 64 register file entries are zero. Values are signed fractions where 0x7FFFFF is just under +1.0 and 0x800000 is -1.0.
- R2: Opcode 0x04 in bits [4:0] sets ACC to ACC + M*REG. M is the signed coefficient in bits [31:16], with 14 fraction bits. REG is the entry addressed by bits [10:5].
- R3: Opcode 0x05 sets ACC to REG + M*(ACC - REG). With M = 0 this loads REG into ACC.
- R4: Opcode 0x06 stores the pre-instruction ACC into REG and sets ACC to M*ACC.
- R5: Opcode 0x07 stores ACC into REG and sets ACC to PACC + M*ACC.
- R6: Opcode 0x08 stores ACC into REG and sets ACC to PACC + M*(PACC - ACC).
- R7: Opcode 0x09 sets ACC to the larger of |ACC| and |M*REG|, so the result is never negative.
- R8: Opcode 0x0A sets ACC to ACC*REG, with both operands taken as 24-bit fractions.
- R9: Opcode 0x0D sets ACC to OFF + M*ACC. OFF is a signed 11-bit value in bits [15:5] with 10 fraction bits, so 0x400 means -1.0.
- R10: Opcodes 0x0E, 0x0F and 0x10 set ACC to ACC AND, OR or XOR the 24-bit field in bits [31:8].
- R11: Every executed opcode above loads PACC with the value ACC held before that instruction.
- R12: Results outside the range are clamped to 0x7FFFFF or 0x800000 instead of wrapping. Discarded fraction bits are truncated toward minus infinity after the add.
- R13: While valid_i is low, or when the opcode is not one listed above, ACC, PACC and the register file keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| acc_o | output | 24 | Accumulator |
| pacc_o | output | 24 | Accumulator value before the last executed instruction |

## Verification
The hardest situations to reach are the clamp boundaries. These are a -1.0 by -1.0 register product, the magnitude of exactly -1.0, and a coefficient near +2.0 applied to a full-scale register. Each needs the accumulator and a register entry driven to extreme values first. The stimulus builds them with bitwise clear, OR and XOR of immediates followed by store instructions, then issues the operation under test. A seeded random stream then mixes legal and illegal opcodes over a few reused register addresses so that stores and reloads interleave.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int INSTR_W   = 32;
  localparam int DATA_W    = 24;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int OFF_W     = 11;
  localparam int REG_AW    = 6;
  localparam int OP_W      = 5;

  localparam logic [OP_W-1:0] OP_MAC_REG   = 5'h04;
  localparam logic [OP_W-1:0] OP_XFADE_REG = 5'h05;
  localparam logic [OP_W-1:0] OP_STORE_SC  = 5'h06;
  localparam logic [OP_W-1:0] OP_STORE_HI  = 5'h07;
  localparam logic [OP_W-1:0] OP_STORE_LO  = 5'h08;
  localparam logic [OP_W-1:0] OP_MAX_ABS   = 5'h09;
  localparam logic [OP_W-1:0] OP_MUL_REG   = 5'h0A;
  localparam logic [OP_W-1:0] OP_SCALE_OFF = 5'h0D;
  localparam logic [OP_W-1:0] OP_AND       = 5'h0E;
  localparam logic [OP_W-1:0] OP_OR        = 5'h0F;
  localparam logic [OP_W-1:0] OP_XOR       = 5'h10;

  typedef enum logic [1:0] {RES_MAC, RES_MAX, RES_MUL, RES_LOGIC} res_sel_e;
  typedef enum logic [2:0] {BASE_ZERO, BASE_ACC, BASE_REG, BASE_PACC, BASE_OFF} base_sel_e;
  typedef enum logic [1:0] {DIFF_ACC, DIFF_REG, DIFF_ACC_REG, DIFF_PACC_ACC} diff_sel_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_op_e;

  typedef struct packed {
    logic      legal;
    logic      wr_reg;
    res_sel_e  res_sel;
    base_sel_e base_sel;
    diff_sel_e diff_sel;
    logic_op_e lg_op;
  } ctrl_t;

  function automatic logic op_is_legal(logic [OP_W-1:0] op);
    return op inside {OP_MAC_REG, OP_XFADE_REG, OP_STORE_SC, OP_STORE_HI,
                      OP_STORE_LO, OP_MAX_ABS, OP_MUL_REG, OP_SCALE_OFF,
                      OP_AND, OP_OR, OP_XOR};
  endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_exec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.legal    = 1'b1;
    ctrl_o.res_sel  = RES_MAC;
    ctrl_o.base_sel = BASE_ZERO;
    ctrl_o.diff_sel = DIFF_ACC;
    ctrl_o.lg_op    = LG_AND;
    unique case (op_i)
      OP_MAC_REG: begin
        ctrl_o.base_sel = BASE_ACC;
        ctrl_o.diff_sel = DIFF_REG;
      end
      OP_XFADE_REG: begin
        ctrl_o.base_sel = BASE_REG;
        ctrl_o.diff_sel = DIFF_ACC_REG;
      end
      OP_STORE_SC: ctrl_o.wr_reg = 1'b1;
      OP_STORE_HI: begin
        ctrl_o.wr_reg   = 1'b1;
        ctrl_o.base_sel = BASE_PACC;
      end
      OP_STORE_LO: begin
        ctrl_o.wr_reg   = 1'b1;
        ctrl_o.base_sel = BASE_PACC;
        ctrl_o.diff_sel = DIFF_PACC_ACC;
      end
      OP_MAX_ABS: begin
        ctrl_o.res_sel  = RES_MAX;
        ctrl_o.diff_sel = DIFF_REG;
      end
      OP_MUL_REG:   ctrl_o.res_sel  = RES_MUL;
      OP_SCALE_OFF: ctrl_o.base_sel = BASE_OFF;
      OP_AND: ctrl_o.res_sel = RES_LOGIC;
      OP_OR: begin
        ctrl_o.res_sel = RES_LOGIC;
        ctrl_o.lg_op   = LG_OR;
      end
      OP_XOR: begin
        ctrl_o.res_sel = RES_LOGIC;
        ctrl_o.lg_op   = LG_XOR;
      end
      default: ctrl_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int DATA_W = 24,
  parameter int AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int D_W  = DATA_W,
  parameter int C_W  = COEF_W,
  parameter int C_FR = COEF_FRAC,
  parameter int O_W  = OFF_W
) (
  input  ctrl_t          ctrl_i,
  input  logic [D_W-1:0] acc_i,
  input  logic [D_W-1:0] pacc_i,
  input  logic [D_W-1:0] reg_i,
  input  logic [C_W-1:0] coef_i,
  input  logic [O_W-1:0] off_i,
  input  logic [D_W-1:0] imm_i,
  output logic [D_W-1:0] res_o
);
  localparam int DIFF_W = D_W + 1;
  localparam int PROD_W = C_W + DIFF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int MUL_W  = 2 * D_W;
  localparam int OFF_SH = D_W - O_W;
  localparam logic [D_W-1:0] VMAX = {1'b0, {(D_W-1){1'b1}}};
  localparam logic [D_W-1:0] VMIN = {1'b1, {(D_W-1){1'b0}}};

  function automatic logic [D_W-1:0] abs_sat(logic [D_W-1:0] x);
    if (x == VMIN)    return VMAX;
    if (x[D_W-1])     return -x;
    return x;
  endfunction

  logic signed [DIFF_W-1:0] a_x, r_x, p_x, diff;
  logic signed [D_W-1:0]    base;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  sum, shf;
  logic [SUM_W-D_W:0]       hi;
  logic [D_W-1:0]           mac_res;

  assign a_x = $signed({acc_i[D_W-1], acc_i});
  assign r_x = $signed({reg_i[D_W-1], reg_i});
  assign p_x = $signed({pacc_i[D_W-1], pacc_i});

  always_comb begin
    unique case (ctrl_i.diff_sel)
      DIFF_REG:      diff = r_x;
      DIFF_ACC_REG:  diff = a_x - r_x;
      DIFF_PACC_ACC: diff = p_x - a_x;
      default:       diff = a_x;
    endcase
    unique case (ctrl_i.base_sel)
      BASE_ACC:  base = $signed(acc_i);
      BASE_REG:  base = $signed(reg_i);
      BASE_PACC: base = $signed(pacc_i);
      BASE_OFF:  base = $signed({off_i, {OFF_SH{1'b0}}});
      default:   base = '0;
    endcase
  end

  // full-width product, truncated once after the add
  assign prod    = PROD_W'($signed(coef_i)) * PROD_W'(diff);
  assign sum     = (SUM_W'(base) <<< C_FR) + SUM_W'(prod);
  assign shf     = sum >>> C_FR;
  assign hi      = shf[SUM_W-1:D_W-1];
  assign mac_res = ((&hi) || !(|hi)) ? shf[D_W-1:0] : (shf[SUM_W-1] ? VMIN : VMAX);

  logic signed [MUL_W-1:0] mfull, mshf;
  logic [MUL_W-D_W:0]      mhi;
  logic [D_W-1:0]          mul_res;

  assign mfull   = MUL_W'($signed(acc_i)) * MUL_W'($signed(reg_i));
  assign mshf    = mfull >>> (D_W - 1);
  assign mhi     = mshf[MUL_W-1:D_W-1];
  assign mul_res = ((&mhi) || !(|mhi)) ? mshf[D_W-1:0] : (mshf[MUL_W-1] ? VMIN : VMAX);

  logic [D_W-1:0] abs_acc, abs_prod, max_res, lg_res;

  assign abs_acc  = abs_sat(acc_i);
  assign abs_prod = abs_sat(mac_res);
  assign max_res  = (abs_acc > abs_prod) ? abs_acc : abs_prod;

  always_comb begin
    unique case (ctrl_i.lg_op)
      LG_OR:   lg_res = acc_i | imm_i;
      LG_XOR:  lg_res = acc_i ^ imm_i;
      default: lg_res = acc_i & imm_i;
    endcase
    unique case (ctrl_i.res_sel)
      RES_MAX:   res_o = max_res;
      RES_MUL:   res_o = mul_res;
      RES_LOGIC: res_o = lg_res;
      default:   res_o = mac_res;
    endcase
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic [DATA_W-1:0]  pacc_o
);
  localparam int ADDR_LSB = OP_W;
  localparam int OFF_LSB  = OP_W;
  localparam int COEF_LSB = INSTR_W - COEF_W;
  localparam int IMM_LSB  = INSTR_W - DATA_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] acc_q, pacc_q, reg_rd, alu_res;
  logic              exec;

  acc_decode u_dec (
    .op_i   (instr_i[OP_W-1:0]),
    .ctrl_o (ctrl)
  );

  assign exec = valid_i && ctrl.legal;

  acc_regfile #(.DATA_W(DATA_W), .AW(REG_AW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (exec && ctrl.wr_reg),
    .addr_i  (instr_i[ADDR_LSB +: REG_AW]),
    .wdata_i (acc_q),
    .rdata_o (reg_rd)
  );

  acc_alu u_alu (
    .ctrl_i (ctrl),
    .acc_i  (acc_q),
    .pacc_i (pacc_q),
    .reg_i  (reg_rd),
    .coef_i (instr_i[COEF_LSB +: COEF_W]),
    .off_i  (instr_i[OFF_LSB +: OFF_W]),
    .imm_i  (instr_i[IMM_LSB +: DATA_W]),
    .res_o  (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pacc_q <= '0;
    end else if (exec) begin
      pacc_q <= acc_q;
      acc_q  <= alu_res;
    end
  end

  assign acc_o  = acc_q;
  assign pacc_o = pacc_q;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
  import acc_exec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] imm_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] pacc_o
);
  assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o) && $stable(pacc_o));

  assert_illegal_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_is_legal(op_i)) |=> $stable(acc_o) && $stable(pacc_o));

  assert_pacc_copy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_is_legal(op_i)) |=> pacc_o == $past(acc_o));

  assert_and_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_AND) |=> acc_o == ($past(acc_o) & $past(imm_i)));

  assert_or_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_OR) |=> acc_o == ($past(acc_o) | $past(imm_i)));

  assert_xor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_XOR) |=> acc_o == ($past(acc_o) ^ $past(imm_i)));

  assert_max_nonneg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_MAX_ABS) |=> !acc_o[DATA_W-1]);
endmodule

bind acc_exec_unit acc_exec_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (instr_i[4:0]),
  .imm_i   (instr_i[31:8]),
  .acc_o   (acc_o),
  .pacc_o  (pacc_o)
);

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [23:0] acc_o, pacc_o;

  int n_run = 0, n_fail = 0;
  logic [23:0] m_acc, m_pacc;
  logic [23:0] m_reg [64];

  always #10 clk = ~clk;

  acc_exec_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .instr_i(instr_i), .acc_o(acc_o), .pacc_o(pacc_o)
  );

  function automatic longint sx(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sat24(longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint mac(longint b, longint m, longint d);
    return sat24(((b <<< 14) + m * d) >>> 14);
  endfunction

  function automatic longint abs24(longint v);
    return sat24(v < 0 ? -v : v);
  endfunction

  function automatic bit legal(logic [4:0] op);
    return op inside {5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
                      5'h0A, 5'h0D, 5'h0E, 5'h0F, 5'h10};
  endfunction

  function automatic string tag_of(logic [4:0] op);
    case (op)
      5'h04: return "R2";
      5'h05: return "R3";
      5'h06: return "R4";
      5'h07: return "R5";
      5'h08: return "R6";
      5'h09: return "R7";
      5'h0A: return "R8";
      5'h0D: return "R9";
      5'h0E, 5'h0F, 5'h10: return "R10";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [4:0] op, logic [5:0] ra, logic [15:0] m);
    return {m, 5'd0, ra, op};
  endfunction

  function automatic logic [31:0] mk_imm(logic [4:0] op, logic [23:0] v);
    return {v, 3'd0, op};
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] ins, string tag = "");
    logic [4:0]  op = ins[4:0];
    logic [5:0]  ra = ins[10:5];
    longint      m  = longint'($signed(ins[31:16]));
    longint      a  = sx(m_acc);
    longint      p  = sx(m_pacc);
    longint      r  = sx(m_reg[ra]);
    longint      off = longint'($signed(ins[15:5]));
    longint      n  = a;
    logic [23:0] imm = ins[31:8];
    string       t  = (tag == "") ? tag_of(op) : tag;
    if (!v) t = "R13";
    valid_i = v;
    instr_i = ins;
    if (v && legal(op)) begin
      case (op)
        5'h04: n = mac(a, m, r);
        5'h05: n = mac(r, m, a - r);
        5'h06: n = mac(0, m, a);
        5'h07: n = mac(p, m, a);
        5'h08: n = mac(p, m, p - a);
        5'h09: begin
          longint x = abs24(mac(0, m, r));
          longint y = abs24(a);
          n = (x > y) ? x : y;
        end
        5'h0A: n = sat24((a * r) >>> 23);
        5'h0D: n = mac(off <<< 13, m, a);
        5'h0E: n = sx(m_acc & imm);
        5'h0F: n = sx(m_acc | imm);
        default: n = sx(m_acc ^ imm);
      endcase
      if (op inside {5'h06, 5'h07, 5'h08}) m_reg[ra] = m_acc;
      m_pacc = m_acc;
      m_acc  = n[23:0];
    end
    @(posedge clk);
    #5;
    check(t, acc_o, m_acc, "acc");
    check((v && legal(op)) ? "R11" : "R13", pacc_o, m_pacc, "pacc");
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [4:0] legal_ops [11] = '{5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
                                    5'h0A, 5'h0D, 5'h0E, 5'h0F, 5'h10};
    void'($urandom(32'd4242));
    m_acc = '0;
    m_pacc = '0;
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", acc_o, 24'h0, "acc after reset");
    check("R1", pacc_o, 24'h0, "pacc after reset");
    for (int i = 0; i < 64; i++) step(1'b1, mk(5'h05, 6'(i), 16'h0), "R1");

    // full-scale positive into reg5, then overdrive it
    step(1'b1, mk_imm(5'h0E, 24'h0));
    step(1'b1, mk_imm(5'h0F, 24'h7FFFFF));
    step(1'b1, mk(5'h06, 6'd5, 16'h4000));
    step(1'b1, mk(5'h05, 6'd5, 16'h0), "R4");
    step(1'b1, mk(5'h04, 6'd5, 16'h7FFF), "R12");
    // -1.0 into reg6, product of -1 and -1
    step(1'b1, mk_imm(5'h10, 24'hFFFFFF));
    check("R10", acc_o, 24'h800000, "xor result");
    step(1'b1, mk(5'h06, 6'd6, 16'h4000));
    step(1'b1, mk(5'h05, 6'd6, 16'h0), "R4");
    step(1'b1, mk(5'h0A, 6'd6, 16'h0), "R12");
    check("R8", acc_o, 24'h7FFFFF, "minus one squared");
    // magnitude of -1.0
    step(1'b1, mk_imm(5'h0E, 24'h0));
    step(1'b1, mk_imm(5'h0F, 24'h800000));
    step(1'b1, mk(5'h09, 6'd0, 16'h0), "R12");
    check("R7", acc_o, 24'h7FFFFF, "abs of minus one");
    // truncation toward minus infinity
    step(1'b1, mk_imm(5'h0E, 24'h0));
    step(1'b1, mk_imm(5'h0F, 24'hFFFFFF));
    step(1'b1, {16'h2000, 11'h0, 5'h0D}, "R12");
    check("R12", acc_o, 24'hFFFFFF, "half of -lsb");
    step(1'b1, mk_imm(5'h0E, 24'h0));
    step(1'b1, mk_imm(5'h0F, 24'h000001));
    step(1'b1, {16'h2000, 11'h0, 5'h0D}, "R12");
    check("R12", acc_o, 24'h000000, "half of +lsb");
    // offset of -1.0 with zero gain
    step(1'b1, {16'h0000, 11'h400, 5'h0D});
    check("R9", acc_o, 24'h800000, "offset -1.0");
    // shelf forms with zero gain swap ACC and PACC
    step(1'b1, mk_imm(5'h0F, 24'h123456));
    step(1'b1, mk(5'h07, 6'd7, 16'h0));
    step(1'b1, mk(5'h08, 6'd8, 16'h0));
    // ignored stimulus
    step(1'b1, mk(5'h0B, 6'd5, 16'h7FFF), "R13");
    step(1'b1, mk(5'h1F, 6'd6, 16'h8000), "R13");
    step(1'b0, mk(5'h06, 6'd5, 16'h4000), "R13");
    step(1'b1, mk(5'h05, 6'd5, 16'h0), "R13");

    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ins = $urandom;
      logic        v   = ($urandom % 10) != 0;
      ins[10:8] = '0;
      if ($urandom % 4 != 0) ins[4:0] = legal_ops[$urandom % 11];
      if (ins[4:0] inside {5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09, 5'h0A})
        ins[7:5] = 3'($urandom % 8);
      step(v, ins);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule